// File: doc/BRIEF.md
# Watchdog timer with power-down flags

This block watches over a running program. A tick chosen from three clock sources advances a prescaler, and the prescaler's carry advances a short watchdog counter. If software does not issue a clear strobe before the counter wraps, the block raises a one-cycle system reset request. When the processor is halted, the same time-out wakes it instead of resetting it.

Two status flags survive a watchdog reset and let boot code work out why it is running. The power-down flag marks that a halt was entered. The time-out flag marks that the watchdog expired. An enable option, fixed at integration time, can switch the whole watchdog off. With the option off, every watchdog action does nothing.

Top module: `wdog_pdto`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it, `pd_flag`, `to_flag`, `wdt_rst_req` and `wake_req` are all 0.
- R2: `src_sel` picks the tick: 2'b00 takes `rc_tick`, 2'b01 takes `instr_tick`, and 2'b10 or 2'b11 take `ext_tick`. Ticks on the unselected inputs have no effect.
- R3: With the watchdog enabled, the time-out falls on the 2^(PRE_W+CNT_W)-th selected tick (4096 with the defaults) after the last restart.
- R4: `clr_wdt`, with the watchdog enabled and the block not halted, restarts the prescaler and the counter from zero and clears both `pd_flag` and `to_flag`.
- R5: A time-out in normal run sets `to_flag` and drives `wdt_rst_req` high for exactly one cycle. Both are seen in the cycle after the expiring tick.
- R6: `halt_cmd` restarts the prescaler and the counter, sets `pd_flag`, clears `to_flag` and enters the halted state. A time-out while halted sets `to_flag`, pulses `wake_req` for one cycle, leaves the halted state and raises no `wdt_rst_req`.
- R7: While halted, `instr_tick` does not advance the watchdog (the instruction clock is stopped). Further `clr_wdt` and `halt_cmd` strobes are ignored.
- R8: With `wdt_en` low, the prescaler and the counter hold at zero, no request is raised and `clr_wdt` leaves the flags unchanged. `halt_cmd` still sets `pd_flag` and enters the halted state.
- R9: When `halt_cmd` and `clr_wdt` arrive in the same cycle, the halt takes effect. A clear or halt in the same cycle as the expiring tick suppresses that time-out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| wdt_en | input | 1 | Watchdog enable option |
| src_sel | input | 2 | Tick source select |
| rc_tick | input | 1 | Tick strobe from the on-chip RC oscillator |
| instr_tick | input | 1 | Instruction-cycle tick strobe |
| ext_tick | input | 1 | External tick strobe |
| clr_wdt | input | 1 | Clear-watchdog command strobe |
| halt_cmd | input | 1 | Halt command strobe |
| wdt_rst_req | output | 1 | One-cycle system reset request |
| wake_req | output | 1 | One-cycle wake-up request while halted |
| pd_flag | output | 1 | Power-down status flag |
| to_flag | output | 1 | Time-out status flag |

## Verification
The assertions check several rules on every cycle. The reset request is a single pulse. Reset and wake never appear together. A rising time-out flag always comes with one of the two requests. Any wake or halted state implies the power-down flag. A restart zeroes the count. A disabled watchdog stays silent. Other properties need a long run to show, and only the bench scenarios exercise them. These are the exact 4096-tick time-out distance for each source, the suppression of a time-out by a coincident clear, the stopped instruction tick during halt, and how the flags behave across clear, halt and reset sequences.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
   // Tick source encoding used by src_sel
   typedef enum logic [1:0] {
      SRC_RC    = 2'b00,
      SRC_INSTR = 2'b01,
      SRC_EXT   = 2'b10,
      SRC_EXT_B = 2'b11
   } wdog_src_e;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
   parameter bit STOP_INSTR_IN_HALT = 1'b1
) (
   input  logic [1:0] src_sel,
   input  logic       rc_tick,
   input  logic       instr_tick,
   input  logic       ext_tick,
   input  logic       halted,
   output logic       tick
);
   import wdog_pkg::*;

   logic instr_eff;

   generate
      if (STOP_INSTR_IN_HALT) begin : g_gate_instr
         // instruction clock stops while the core is halted (R7)
         assign instr_eff = instr_tick & ~halted;
      end else begin : g_free_instr
         logic unused_halted;
         assign unused_halted = halted;
         assign instr_eff = instr_tick;
      end
   endgenerate

   always_comb begin
      unique case (wdog_src_e'(src_sel))
         SRC_RC:    tick = rc_tick;
         SRC_INSTR: tick = instr_eff;
         default:   tick = ext_tick;
      endcase
   end
endmodule

// File: rtl/wdog_chain.sv
module wdog_chain #(
   parameter int PRE_W = 8,
   parameter int CNT_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic restart,
   output logic expire
);
   generate
      if (PRE_W < 1 || PRE_W > 24) begin : g_bad_pre
         $error("wdog_chain: PRE_W out of range");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("wdog_chain: CNT_W out of range");
      end
   endgenerate

   logic [PRE_W-1:0] pre_q;
   logic [CNT_W-1:0] cnt_q;
   logic             pre_carry;

   assign pre_carry = tick & (&pre_q);
   assign expire    = ~restart & pre_carry & (&cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (restart) begin
         pre_q <= '0;
         cnt_q <= '0;
      end else if (tick) begin
         pre_q <= pre_q + 1'b1;
         if (pre_carry) cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: a restart leaves both stages at zero on the next cycle
   assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (pre_q == '0 && cnt_q == '0));
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
   input  logic clk,
   input  logic rst_n,
   input  logic wdt_en,
   input  logic clr_wdt,
   input  logic halt_cmd,
   input  logic expire,
   output logic restart,
   output logic halted,
   output logic pd_flag,
   output logic to_flag,
   output logic wdt_rst_req,
   output logic wake_req
);
   logic take_halt, take_clr;

   assign take_halt = ~halted & halt_cmd;
   assign take_clr  = ~halted & clr_wdt & wdt_en;
   assign restart   = ~wdt_en | take_halt | take_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted      <= 1'b0;
         pd_flag     <= 1'b0;
         to_flag     <= 1'b0;
         wdt_rst_req <= 1'b0;
         wake_req    <= 1'b0;
      end else begin
         wdt_rst_req <= 1'b0;
         wake_req    <= 1'b0;
         if (take_halt) begin
            halted  <= 1'b1;
            pd_flag <= 1'b1;
            to_flag <= 1'b0;
         end else if (take_clr) begin
            pd_flag <= 1'b0;
            to_flag <= 1'b0;
         end else if (expire) begin
            to_flag <= 1'b1;
            if (halted) begin
               wake_req <= 1'b1;
               halted   <= 1'b0;
            end else begin
               wdt_rst_req <= 1'b1;
            end
         end
      end
   end

   // R5: reset request lasts a single cycle
   assert_rst_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst_req |=> !wdt_rst_req);
   // R5: time-out flag only rises together with a request
   assert_to_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(to_flag) |-> (wdt_rst_req || wake_req));
   // R6: reset and wake are never requested together
   assert_req_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wdt_rst_req && wake_req));
   // R6: a wake-up is only possible after a halt marked power-down
   assert_wake_pd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req |-> pd_flag);
   // R7: power-down flag holds for the whole halted state
   assert_halt_pd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |-> pd_flag);
   // R8: a disabled watchdog raises no request
   assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wdt_en) |-> (!wdt_rst_req && !wake_req));
endmodule

// File: rtl/wdog_pdto.sv
module wdog_pdto #(
   parameter int PRE_W              = 8,
   parameter int CNT_W              = 4,
   parameter bit STOP_INSTR_IN_HALT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wdt_en,
   input  logic [1:0] src_sel,
   input  logic       rc_tick,
   input  logic       instr_tick,
   input  logic       ext_tick,
   input  logic       clr_wdt,
   input  logic       halt_cmd,
   output logic       wdt_rst_req,
   output logic       wake_req,
   output logic       pd_flag,
   output logic       to_flag
);
   localparam int TOTAL_W = PRE_W + CNT_W;

   generate
      if (TOTAL_W > 32) begin : g_bad_total
         $error("wdog_pdto: time-out span too wide");
      end
   endgenerate

   logic tick, expire, restart, halted;

   wdog_tick_sel #(.STOP_INSTR_IN_HALT(STOP_INSTR_IN_HALT)) u_sel (
      .src_sel    (src_sel),
      .rc_tick    (rc_tick),
      .instr_tick (instr_tick),
      .ext_tick   (ext_tick),
      .halted     (halted),
      .tick       (tick)
   );

   wdog_chain #(.PRE_W(PRE_W), .CNT_W(CNT_W)) u_chain (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (tick),
      .restart (restart),
      .expire  (expire)
   );

   wdog_status u_status (
      .clk         (clk),
      .rst_n       (rst_n),
      .wdt_en      (wdt_en),
      .clr_wdt     (clr_wdt),
      .halt_cmd    (halt_cmd),
      .expire      (expire),
      .restart     (restart),
      .halted      (halted),
      .pd_flag     (pd_flag),
      .to_flag     (to_flag),
      .wdt_rst_req (wdt_rst_req),
      .wake_req    (wake_req)
   );
endmodule

// File: tb/wdog_pdto_tb_top.sv
`timescale 1ns/1ps
module wdog_pdto_tb_top;
   localparam int PRE_W   = 8;
   localparam int CNT_W   = 4;
   localparam int PRE_MAX = (1 << PRE_W) - 1;
   localparam int CNT_MAX = (1 << CNT_W) - 1;
   localparam int SPAN    = 1 << (PRE_W + CNT_W);

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic       rst_n = 1'b0, wdt_en = 1'b1;
   logic [1:0] src_sel = 2'b00;
   logic       rc_tick = 1'b0, instr_tick = 1'b0, ext_tick = 1'b0;
   logic       clr_wdt = 1'b0, halt_cmd = 1'b0;
   logic       wdt_rst_req, wake_req, pd_flag, to_flag;

   wdog_pdto #(.PRE_W(PRE_W), .CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .src_sel(src_sel),
      .rc_tick(rc_tick), .instr_tick(instr_tick), .ext_tick(ext_tick),
      .clr_wdt(clr_wdt), .halt_cmd(halt_cmd), .wdt_rst_req(wdt_rst_req),
      .wake_req(wake_req), .pd_flag(pd_flag), .to_flag(to_flag));

   int    vectors = 0, fails = 0, cyc = 0;
   string tag = "R1";
   int    m_pre = 0, m_cnt = 0;
   bit    m_pd = 0, m_to = 0, m_halt = 0, m_rst = 0, m_wake = 0;

   // R2 / R7: which tick reaches the watchdog
   function automatic bit pick_tick(logic [1:0] s, bit rc, bit ins, bit ext, bit hlt);
      case (s)
         2'b00:   return rc;
         2'b01:   return ins & ~hlt;
         default: return ext;
      endcase
   endfunction

   task automatic model_edge();
      bit t, rs, ex;
      if (!rst_n) begin
         m_pre = 0; m_cnt = 0; m_pd = 0; m_to = 0; m_halt = 0; m_rst = 0; m_wake = 0;
         return;
      end
      m_rst = 0; m_wake = 0;
      t  = pick_tick(src_sel, rc_tick, instr_tick, ext_tick, m_halt);
      rs = !wdt_en || (!m_halt && (halt_cmd || (clr_wdt && wdt_en)));
      ex = t && !rs && m_pre == PRE_MAX && m_cnt == CNT_MAX;
      if (!m_halt && halt_cmd) begin
         m_halt = 1; m_pd = 1; m_to = 0;
      end else if (!m_halt && clr_wdt && wdt_en) begin
         m_pd = 0; m_to = 0;
      end else if (ex) begin
         m_to = 1;
         if (m_halt) begin m_wake = 1; m_halt = 0; end
         else m_rst = 1;
      end
      if (rs) begin
         m_pre = 0; m_cnt = 0;
      end else if (t) begin
         if (m_pre == PRE_MAX) begin m_pre = 0; m_cnt = (m_cnt + 1) % (CNT_MAX + 1); end
         else m_pre++;
      end
   endtask

   task automatic check1(string what, logic act, bit exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic step();
      model_edge();
      @(posedge clk);
      @(negedge clk);
      check1("wdt_rst_req", wdt_rst_req, m_rst);
      check1("wake_req", wake_req, m_wake);
      check1("pd_flag", pd_flag, m_pd);
      check1("to_flag", to_flag, m_to);
   endtask

   task automatic noise();
      rc_tick = 1'($urandom_range(0, 1));
      instr_tick = 1'($urandom_range(0, 1));
      ext_tick = 1'($urandom_range(0, 1));
   endtask

   task automatic force_sel(logic [1:0] s);
      noise();
      case (s)
         2'b00:   rc_tick = 1'b1;
         2'b01:   instr_tick = 1'b1;
         default: ext_tick = 1'b1;
      endcase
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 190000) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer than 190000", cyc);
            summary();
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'h5eed_0042));
      @(negedge clk);
      // R1: reset state
      tag = "R1";
      for (int i = 0; i < 4; i++) begin noise(); step(); end
      rst_n = 1'b1; step();

      // R2: each source alone reaches a time-out, others are noise
      tag = "R2";
      for (int s = 0; s < 4; s++) begin
         src_sel = 2'(s);
         clr_wdt = 1'b1; force_sel(2'(s)); step(); clr_wdt = 1'b0;
         for (int i = 0; i < SPAN + 8; i++) begin force_sel(2'(s)); step(); end
      end
      // R2: unselected ticks only: no progress
      src_sel = 2'b00; clr_wdt = 1'b1; step(); clr_wdt = 1'b0;
      for (int i = 0; i < SPAN + 8; i++) begin
         rc_tick = 1'b0; instr_tick = 1'b1; ext_tick = 1'b1; step();
      end

      // R3 / R5: two back-to-back time-outs on a steady tick
      tag = "R5";
      src_sel = 2'b01; clr_wdt = 1'b1; instr_tick = 1'b1; step(); clr_wdt = 1'b0;
      for (int i = 0; i < 2 * SPAN + 10; i++) step();
      tag = "R3";
      check1("to_flag after two spans", to_flag, 1'b1);

      // R4: periodic clears keep the watchdog quiet and drop TO
      tag = "R4";
      for (int i = 0; i < 3 * SPAN; i++) begin
         clr_wdt = (i % 3000 == 0);
         step();
      end
      clr_wdt = 1'b0;
      check1("to_flag cleared", to_flag, 1'b0);

      // R6: halt, then wake on the external tick
      tag = "R6";
      src_sel = 2'b10; ext_tick = 1'b1; halt_cmd = 1'b1; step(); halt_cmd = 1'b0;
      check1("pd_flag after halt", pd_flag, 1'b1);
      for (int i = 0; i < SPAN + 8; i++) step();

      // R7: halted with the instruction tick: no wake; commands ignored
      tag = "R7";
      src_sel = 2'b01; instr_tick = 1'b1; halt_cmd = 1'b1; step(); halt_cmd = 1'b0;
      for (int i = 0; i < SPAN + 100; i++) begin
         clr_wdt = (i % 1000 == 5); halt_cmd = (i % 1500 == 7); step();
      end
      clr_wdt = 1'b0; halt_cmd = 1'b0;
      check1("pd_flag still set", pd_flag, 1'b1);
      src_sel = 2'b00; rc_tick = 1'b1;
      for (int i = 0; i < SPAN + 8; i++) step();

      // R8: disabled watchdog
      tag = "R8";
      wdt_en = 1'b0;
      for (int i = 0; i < SPAN + 500; i++) begin
         noise(); src_sel = 2'($urandom_range(0, 3));
         clr_wdt = ($urandom_range(0, 300) == 0); step();
      end
      clr_wdt = 1'b0; halt_cmd = 1'b1; step(); halt_cmd = 1'b0;
      check1("pd_flag halt while disabled", pd_flag, 1'b1);
      for (int i = 0; i < 50; i++) begin noise(); step(); end
      rst_n = 1'b0; step(); rst_n = 1'b1; wdt_en = 1'b1; step();

      // R9: clear on the expiring tick suppresses the time-out
      tag = "R9";
      src_sel = 2'b01; instr_tick = 1'b1; clr_wdt = 1'b1; step(); clr_wdt = 1'b0;
      for (int i = 0; i < SPAN - 1; i++) step();
      clr_wdt = 1'b1; step(); clr_wdt = 1'b0;
      for (int i = 0; i < 10; i++) step();
      check1("to_flag after suppressed time-out", to_flag, 1'b0);
      // R9: halt and clear together: halt wins
      halt_cmd = 1'b1; clr_wdt = 1'b1; step(); halt_cmd = 1'b0; clr_wdt = 1'b0;
      check1("pd_flag halt beats clear", pd_flag, 1'b1);
      src_sel = 2'b00; rc_tick = 1'b1;
      for (int i = 0; i < SPAN + 8; i++) step();

      // R3: constrained random mix
      tag = "R3";
      for (int i = 0; i < 40000; i++) begin
         if (i % 2000 == 0) src_sel = 2'($urandom_range(0, 3));
         rc_tick = ($urandom_range(0, 9) < 7);
         instr_tick = ($urandom_range(0, 9) < 7);
         ext_tick = ($urandom_range(0, 9) < 7);
         clr_wdt = ($urandom_range(0, 4999) == 0);
         halt_cmd = ($urandom_range(0, 7999) == 0);
         if (i % 9000 == 100) wdt_en = 1'b0;
         if (i % 9000 == 400) wdt_en = 1'b1;
         step();
      end
      summary();
      $finish;
   end
endmodule